// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog timer that counts a slow, free-running tick delivered as a clock-enable on the system clock. It shares one 8-bit divider with a general-purpose timer. An ownership bit in a small option register decides where the divider sits. It either sits behind the watchdog, where it stretches the timeout, or in front of the timer input, where it thins out the timer increment strobe. The timer counter itself is not part of the block. The block only produces the strobe that would advance it.

Software keeps the watchdog quiet with a clear pulse. A sleep-entry pulse restarts the full timeout so that a sleeping system wakes after a known interval. A timeout while awake requests a device reset. A timeout while asleep requests a wake-up reset instead. A configuration enable turns the whole watchdog off.

Top module: `guard_timer_top`

## Requirements
- R1: With option bit 3 (owner) at 0, a timeout occurs after exactly BASE_TICKS watchdog ticks counted from a clear, whatever the ratio field holds.
- R2: With option bit 3 at 1, a timeout occurs after BASE_TICKS × 2^k ticks counted from a clear, where k is option bits 2:0 (so 1:1 up to 1:128).
- R3: Option bit 3 selects the divider owner: 1 means the watchdog and 0 means the timer. While the watchdog owns it, every timer event gives one tmrInc pulse with no division.
- R4: A wdtClr pulse zeroes the watchdog count, and also the divider when the watchdog owns it, so a full timeout restarts from that point. While the timer owns the divider, wdtClr leaves its count untouched.
- R5: A sleepReq pulse zeroes the watchdog count and the watchdog-owned divider, so the full timeout passes before the wake request.
- R6: A timeout while awake pulses resetReq. A timeout after sleepReq pulses wakeReq instead and returns the block to the awake state. The two never rise together.
- R7: With cfgEnable at 0, neither resetReq nor wakeReq is ever raised.
- R8: Reset loads all ones into the option register, so with no write the watchdog owns the divider at 1:128 and times out after BASE_TICKS × 128 ticks.
- R9: An option write that changes bit 3 or bits 2:0 clears the divider count.
- R10: Timer events are chosen by option bit 5. At 0 every clock is an event. At 1 the tmrPin input is used, where bit 4 at 0 counts rising edges and at 1 counts falling edges. While the timer owns the divider, tmrInc pulses once per 2^k events.
- R11: resetReq, wakeReq and tmrInc are registered. Each is high for the one clock that follows the edge sampling the completing tick or event, and resetReq and wakeReq last exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Configuration enable for the watchdog |
| optWe | input | 1 | Option register write strobe |
| optData | input | 6 | Option data: [5] timer source, [4] edge, [3] owner, [2:0] ratio |
| wdtClr | input | 1 | Clear-watchdog pulse |
| sleepReq | input | 1 | Sleep-entry pulse |
| wdtTick | input | 1 | Watchdog tick clock-enable |
| tmrPin | input | 1 | External timer clock source |
| resetReq | output | 1 | Device-reset request pulse |
| wakeReq | output | 1 | Wake-up-reset request pulse |
| tmrInc | output | 1 | Timer increment strobe |

## Verification
The timeout is measured in ticks from a clear under several settings: the reset default, three different ratios with the watchdog as owner, and the timer as owner. These settings separate a correct divider selection from one stuck at a single ratio, and a correct ownership mux from one that always divides. Clear and sleep pulses arrive partway through a period, when the divider already holds a partial count, which exposes a divider that is not reset with the counter. The timer path is tried with the internal source and with rising and falling pin edges, and with a clear and a ratio change between edges. These show whether the divider is correctly left alone or cleared in each case.

// File: rtl/guard_pkg.sv
package guard_pkg;
  // option field positions decoded by the control
  localparam int OPT_RATIO_LSB = 0;
  localparam int OPT_OWNER     = 3;
  localparam int OPT_EDGE      = 4;
  localparam int OPT_SRC       = 5;

  typedef struct packed {
    logic wdtStep;
    logic wdtClear;
    logic psStep;
    logic psClear;
  } guard_strobe_t;
endpackage

// File: rtl/guard_datapath.sv
module guard_datapath #(
  parameter int BASE_TICKS = 18,
  parameter int PS_WIDTH   = 8,
  parameter int RATIO_BITS = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  guard_pkg::guard_strobe_t  strobe,
  input  logic [RATIO_BITS-1:0]     ratio,
  output logic                      wdtAtMax,
  output logic                      psAtTerm
);
  localparam int CNT_W = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1;

  logic [CNT_W-1:0]    wdtCnt;
  logic [PS_WIDTH-1:0] psCnt;
  logic [PS_WIDTH-1:0] psTerm;

  assign wdtAtMax = (wdtCnt == CNT_W'(BASE_TICKS - 1));
  assign psTerm   = (PS_WIDTH'(1) << ratio) - PS_WIDTH'(1);
  assign psAtTerm = (psCnt == psTerm);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdtCnt <= '0;
    end else if (strobe.wdtClear) begin
      wdtCnt <= '0;
    end else if (strobe.wdtStep) begin
      wdtCnt <= wdtAtMax ? '0 : wdtCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (strobe.psClear) begin
      psCnt <= '0;
    end else if (strobe.psStep) begin
      psCnt <= psAtTerm ? '0 : psCnt + PS_WIDTH'(1);
    end
  end
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl #(
  parameter int RATIO_BITS = 3,
  parameter int OPT_W      = RATIO_BITS + 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgEnable,
  input  logic                      optWe,
  input  logic [OPT_W-1:0]          optData,
  input  logic                      wdtClr,
  input  logic                      sleepReq,
  input  logic                      wdtTick,
  input  logic                      tmrPin,
  input  logic                      wdtAtMax,
  input  logic                      psAtTerm,
  output guard_pkg::guard_strobe_t  strobe,
  output logic [RATIO_BITS-1:0]     ratio,
  output logic                      resetReq,
  output logic                      wakeReq,
  output logic                      tmrInc
);
  import guard_pkg::*;

  logic [OPT_W-1:0] optReg;
  logic asleep;
  logic pinPrev;
  logic ownerWdt, srcPin, edgeFall;
  logic cfgChange, quietOp, baseWrap, fire, tmrEvent, incNext;

  assign ownerWdt = optReg[OPT_OWNER];
  assign srcPin   = optReg[OPT_SRC];
  assign edgeFall = optReg[OPT_EDGE];
  assign ratio    = optReg[OPT_RATIO_LSB +: RATIO_BITS];

  always_comb begin
    cfgChange = optWe &&
      ((optData[OPT_OWNER] != ownerWdt) ||
       (optData[OPT_RATIO_LSB +: RATIO_BITS] != ratio));
    quietOp   = wdtClr || sleepReq;
    strobe.wdtStep  = cfgEnable && wdtTick && !quietOp;
    baseWrap  = strobe.wdtStep && wdtAtMax;
    fire      = ownerWdt ? (baseWrap && psAtTerm) : baseWrap;
    strobe.wdtClear = !cfgEnable || quietOp || fire;
    if (srcPin)
      tmrEvent = edgeFall ? (pinPrev && !tmrPin) : (!pinPrev && tmrPin);
    else
      tmrEvent = 1'b1;
    strobe.psStep  = ownerWdt ? baseWrap : tmrEvent;
    strobe.psClear = cfgChange ||
                     (ownerWdt && (!cfgEnable || quietOp || fire));
    incNext = ownerWdt ? tmrEvent : (tmrEvent && psAtTerm && !strobe.psClear);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      optReg   <= '1;
      asleep   <= 1'b0;
      pinPrev  <= 1'b0;
      resetReq <= 1'b0;
      wakeReq  <= 1'b0;
      tmrInc   <= 1'b0;
    end else begin
      if (optWe) optReg <= optData;
      if (sleepReq) asleep <= 1'b1;
      else if (fire && asleep) asleep <= 1'b0;
      pinPrev  <= tmrPin;
      resetReq <= fire && !asleep;
      wakeReq  <= fire && asleep;
      tmrInc   <= incNext;
    end
  end
endmodule

// File: rtl/guard_timer_top.sv
module guard_timer_top #(
  parameter int BASE_TICKS = 18,
  parameter int PS_WIDTH   = 8,
  parameter int RATIO_BITS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEnable,
  input  logic       optWe,
  input  logic [5:0] optData,
  input  logic       wdtClr,
  input  logic       sleepReq,
  input  logic       wdtTick,
  input  logic       tmrPin,
  output logic       resetReq,
  output logic       wakeReq,
  output logic       tmrInc
);
  guard_pkg::guard_strobe_t strobe;
  logic [RATIO_BITS-1:0] ratio;
  logic wdtAtMax, psAtTerm;

  guard_ctrl #(.RATIO_BITS(RATIO_BITS), .OPT_W(6)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .optWe(optWe),
    .optData(optData), .wdtClr(wdtClr), .sleepReq(sleepReq),
    .wdtTick(wdtTick), .tmrPin(tmrPin), .wdtAtMax(wdtAtMax),
    .psAtTerm(psAtTerm), .strobe(strobe), .ratio(ratio),
    .resetReq(resetReq), .wakeReq(wakeReq), .tmrInc(tmrInc)
  );

  guard_datapath #(
    .BASE_TICKS(BASE_TICKS), .PS_WIDTH(PS_WIDTH), .RATIO_BITS(RATIO_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ratio(ratio),
    .wdtAtMax(wdtAtMax), .psAtTerm(psAtTerm)
  );
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk (
  input logic clk,
  input logic rstN,
  input logic cfgEnable,
  input logic wdtClr,
  input logic sleepReq,
  input logic resetReq,
  input logic wakeReq
);
  // R6: reset and wake requests are exclusive
  a_r6_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetReq, wakeReq}));
  // R7: disabled watchdog raises nothing
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (!resetReq && !wakeReq));
  // R4: clear cycle cannot complete a timeout
  a_r4_clear_blocks: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |=> (!resetReq && !wakeReq));
  // R5: sleep entry cannot complete a timeout
  a_r5_sleep_blocks: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> (!resetReq && !wakeReq));
  // R11: single-cycle requests
  a_r11_reset_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  a_r11_wake_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq);
endmodule

bind guard_timer_top guard_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .wdtClr(wdtClr),
  .sleepReq(sleepReq), .resetReq(resetReq), .wakeReq(wakeReq)
);

// File: tb/tb_guard_timer_top.sv
module tb_guard_timer_top;
  localparam int BASE = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, cfgEnable = 1'b1, optWe = 1'b0;
  logic [5:0] optData = '0;
  logic wdtClr = 1'b0, sleepReq = 1'b0, wdtTick = 1'b0, tmrPin = 1'b0;
  logic resetReq, wakeReq, tmrInc;
  int nChecks = 0, nFail = 0;

  guard_timer_top #(.BASE_TICKS(BASE)) dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .optWe(optWe),
    .optData(optData), .wdtClr(wdtClr), .sleepReq(sleepReq),
    .wdtTick(wdtTick), .tmrPin(tmrPin), .resetReq(resetReq),
    .wakeReq(wakeReq), .tmrInc(tmrInc)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // option layout: [5] src pin, [4] falling edge, [3] watchdog owner, [2:0] ratio
  function automatic logic [5:0] opt(input bit src, input bit fall,
                                     input bit own, input int r);
    return {src, fall, own, 3'(r)};
  endfunction

  task automatic writeOpt(input logic [5:0] v);
    @(negedge clk); optWe = 1'b1; optData = v;
    @(negedge clk); optWe = 1'b0;
  endtask

  task automatic doClear();
    @(negedge clk); wdtClr = 1'b1;
    @(negedge clk); wdtClr = 1'b0;
  endtask

  task automatic doSleep();
    @(negedge clk); sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
  endtask

  // kind: 0 none, 1 resetReq, 2 wakeReq
  task automatic runTicks(input int maxN, output int at, output int kind);
    at = 0; kind = 0;
    for (int i = 1; i <= maxN; i++) begin
      @(negedge clk); wdtTick = 1'b1;
      @(posedge clk); #1;
      if (resetReq || wakeReq) begin
        at = i; kind = resetReq ? 1 : 2;
        break;
      end
    end
    @(negedge clk); wdtTick = 1'b0;
    if (at != 0) begin
      @(posedge clk); #1;
      chk("R11 request lasts one clock", int'(resetReq | wakeReq), 0);
    end
  endtask

  task automatic pinSet(input logic v, output int inc);
    @(negedge clk); tmrPin = v;
    @(posedge clk); #1; inc = int'(tmrInc);
  endtask

  task automatic riseFall(output int incRise, output int incFall);
    pinSet(1'b1, incRise);
    pinSet(1'b0, incFall);
  endtask

  task automatic t_reset();
    int at, kind;
    chk("R8 resetReq idle", int'(resetReq), 0);
    chk("R8 wakeReq idle", int'(wakeReq), 0);
    chk("R8 tmrInc idle", int'(tmrInc), 0);
    runTicks(BASE * 128 + 20, at, kind);
    chk("R8 default 1:128 period", at, BASE * 128);
    chk("R6 awake timeout is resetReq", kind, 1);
  endtask

  task automatic t_ratios();
    int at, kind;
    int rs[3] = '{0, 2, 5};
    foreach (rs[j]) begin
      writeOpt(opt(0, 0, 1, rs[j]));
      doClear();
      runTicks(BASE * 128 + 20, at, kind);
      chk($sformatf("R2 period ratio %0d", rs[j]), at, BASE << rs[j]);
    end
    writeOpt(opt(1, 0, 0, 5));
    doClear();
    runTicks(BASE * 128 + 20, at, kind);
    chk("R1 timer-owned unscaled period", at, BASE);
  endtask

  task automatic t_clear();
    int at, kind;
    writeOpt(opt(1, 0, 1, 2));
    doClear();
    runTicks(10, at, kind);
    chk("R4 no timeout before clear", at, 0);
    doClear();
    runTicks(100, at, kind);
    chk("R4 full period after clear", at, BASE * 4);
    writeOpt(opt(1, 0, 1, 0));
    doClear();
    runTicks(3, at, kind);
    doClear();
    runTicks(100, at, kind);
    chk("R4 counter zeroed by clear", at, BASE);
  endtask

  task automatic t_sleep();
    int at, kind;
    writeOpt(opt(1, 0, 1, 1));
    doClear();
    runTicks(5, at, kind);
    chk("R5 no timeout before sleep", at, 0);
    doSleep();
    runTicks(100, at, kind);
    chk("R5 full period in sleep", at, BASE * 2);
    chk("R6 asleep timeout is wakeReq", kind, 2);
    runTicks(100, at, kind);
    chk("R6 awake again after wake", kind, 1);
  endtask

  task automatic t_disable();
    int at, kind;
    @(negedge clk); cfgEnable = 1'b0;
    runTicks(BASE * 128 + 50, at, kind);
    chk("R7 disabled never times out", at, 0);
    @(negedge clk); cfgEnable = 1'b1;
    doClear();
  endtask

  task automatic t_internal();
    int cnt;
    writeOpt(opt(0, 0, 0, 2));
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1; cnt += int'(tmrInc);
    end
    chk("R10 internal source divided by 4", cnt, 10);
    writeOpt(opt(0, 0, 1, 2));
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1; cnt += int'(tmrInc);
    end
    chk("R3 watchdog-owned timer undivided", cnt, 10);
  endtask

  task automatic t_external();
    int a, b;
    writeOpt(opt(1, 0, 0, 0));
    riseFall(a, b);
    chk("R10 rising edge counted", a, 1);
    chk("R10 falling edge ignored", b, 0);
    writeOpt(opt(1, 1, 0, 0));
    riseFall(a, b);
    chk("R10 rising edge ignored in falling mode", a, 0);
    chk("R10 falling edge counted", b, 1);
  endtask

  task automatic t_timer_clear();
    int a, b;
    writeOpt(opt(1, 0, 0, 1));
    riseFall(a, b);
    chk("R10 first of two edges", a, 0);
    doClear();
    riseFall(a, b);
    chk("R4 timer divider kept across clear", a, 1);
  endtask

  task automatic t_cfg_change();
    int a, b;
    riseFall(a, b);
    chk("R9 partial count before write", a, 0);
    writeOpt(opt(1, 0, 0, 2));
    riseFall(a, b); chk("R9 edge 1 after write", a, 0);
    riseFall(a, b); chk("R9 edge 2 after write", a, 0);
    riseFall(a, b); chk("R9 edge 3 after write", a, 0);
    riseFall(a, b); chk("R9 edge 4 after write", a, 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    t_reset();
    t_ratios();
    t_clear();
    t_sleep();
    t_disable();
    t_internal();
    t_external();
    t_timer_clear();
    t_cfg_change();
    summary();
    $finish;
  end
endmodule